// File: doc/BRIEF.md
# Round-Robin ADC Scan Controller

This block sits between a simple 32-bit register port and an abstract analog converter. Software programs one control word that selects the engine enable, a three-bit power mode, the voltage reference, the compensation and battery-sense modes, and a mask of up to sixteen channels. While the engine is enabled and in normal mode, each sample tick starts one conversion. The scan takes the next enabled channel in round-robin order and skips the disabled ones. Each finished conversion lands in its own 16-bit result slot.

After normal mode is entered, the controller counts a fixed number of sample ticks and then raises a sticky ready flag in the control word. The flag drops again as soon as the engine stops running. The compensation, reference, trim and battery-sense settings are passed out to the converter. Battery sensing takes effect only while channel 7 is being converted.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, every register reads zero (control word at 0x00, result words, trim at 0xC4), and no conversion is started.
- R2: Control word layout. Bit 0 is the engine enable. Bits [3:1] are the power mode (0 down, 1 standby, 7 normal). Bit 4 is compensation. Bit 5 is auto-compensation. Bits [7:6] are the reference select. Bit 12 is the channel-7 battery mode. Bit 13 is the battery-sense enable. Bits [31:16] enable channels 0 to 15. All of these read back as written. Bit 8 is the read-only ready flag. Bits 9-11 and 14-15 read zero.
- R3: A conversion starts only while bit 0 is 1 and the mode is 7. A sample tick in that state starts one conversion: `cnv_start` pulses for one cycle on the clock edge after the tick. Standby, power down, or a cleared enable start nothing.
- R4: The channel picked is the first enabled channel above the one last completed, wrapping at 15. After reset the search starts from channel 0.
- R5: While a conversion is outstanding, sample ticks are dropped and `cnv_chan` stays constant.
- R6: On `cnv_done`, the 10-bit result is stored zero-extended in that channel's 16-bit slot at byte offset 0x10 + 2n. A 32-bit read at 0x10 + 4w returns channel 2w in bits [15:0] and channel 2w+1 in bits [31:16]. A slot keeps its value until that channel converts again. Writes to these offsets are ignored.
- R7: The ready flag (bit 8) is set on the INIT_TICKS-th sample tick counted while the engine is running. It stays set while running. It clears, and its count restarts, whenever the enable is 0 or the mode is not 7.
- R8: `cnv_comp`, `cnv_auto_comp` and `cnv_ref` follow control bits 4, 5 and [7:6]. `cnv_bat` is high only while a conversion of channel 7 is outstanding and bits 12 and 13 are both set.
- R9: The trim register at 0xC4 holds 4 bits. It reads zero above bit 3 and drives `cnv_trim`. Any other offset, including 0xC8 to 0xD0, reads zero.
- R10: Leaving running state abandons an outstanding conversion. A `cnv_done` that arrives afterwards changes no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address; bits [1:0] ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sample_tick | input | 1 | One-cycle conversion-rate tick |
| cnv_start | output | 1 | One-cycle start pulse to the converter |
| cnv_chan | output | 4 | Channel being converted |
| cnv_done | input | 1 | Converter finished; result valid |
| cnv_result | input | 10 | Conversion result |
| cnv_comp | output | 1 | Force input to mid-reference |
| cnv_auto_comp | output | 1 | Auto-compensation enable |
| cnv_ref | output | 2 | Reference select |
| cnv_bat | output | 1 | Battery divider active for this conversion |
| cnv_trim | output | 4 | Compensation trim value |

## Verification
The assertions assume the following about the inputs:
- `cnv_done` is meaningful only while a conversion is outstanding.
- `sample_tick` is a single-cycle pulse.
- Register writes use word-aligned addresses.

The stimulus meets these conditions with a converter model and a tick generator. The converter model raises `cnv_done` only for a given number of cycles after `cnv_start`. The tick generator uses a programmable period. Stray `cnv_done` pulses are injected on purpose only after an abandon, to check that they are dropped.

// File: rtl/adc_scan_pkg.sv
// Package: shared types and address constants for the ADC scan controller.
// Assumes at most 16 channels and a word-indexed register map.
package adc_scan_pkg;
    localparam int MAX_CH   = 16;
    localparam int TRIM_W   = 4;
    localparam int SLOT_W   = 16;
    localparam int BAT_CH   = 7;
    localparam logic [5:0] CTRL_IDX = 6'h00;
    localparam int         RES_IDX0 = 4;
    localparam logic [5:0] TRIM_IDX = 6'h31;
    localparam logic [2:0] PM_DOWN  = 3'd0;
    localparam logic [2:0] PM_STBY  = 3'd1;
    localparam logic [2:0] PM_NORM  = 3'd7;

    typedef struct packed {
        logic [MAX_CH-1:0] ch_en;
        logic              bat_en;
        logic              ch7_bat;
        logic [1:0]        ref_sel;
        logic              auto_comp;
        logic              comp;
        logic [2:0]        mode;
        logic              eng_en;
    } ctrl_t;
endpackage

// File: rtl/adc_ctrl_regs.sv
// Control and trim registers. Decodes the running condition.
// Assumes word-index addressing; writes to other indices are ignored here.
module adc_ctrl_regs
    import adc_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [5:0]          idx,
    input  logic [31:0]         wdata,
    output ctrl_t               ctrl,
    output logic [TRIM_W-1:0]   trim,
    output logic                running
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[11:8], wdata[15:14]};

    // Capture software writes into the control word and trim register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            trim <= '0;
        end else if (wr) begin
            if (idx == CTRL_IDX) begin
                ctrl.ch_en     <= wdata[31:16];
                ctrl.bat_en    <= wdata[13];
                ctrl.ch7_bat   <= wdata[12];
                ctrl.ref_sel   <= wdata[7:6];
                ctrl.auto_comp <= wdata[5];
                ctrl.comp      <= wdata[4];
                ctrl.mode      <= wdata[3:1];
                ctrl.eng_en    <= wdata[0];
            end
            if (idx == TRIM_IDX) begin
                trim <= wdata[TRIM_W-1:0];
            end
        end
    end

    // Engine converts only when enabled and in normal power mode.
    assign running = ctrl.eng_en && (ctrl.mode == PM_NORM);
endmodule

// File: rtl/adc_init_timer.sv
// Power-up ready flag: counts sample ticks while running and sets a sticky flag.
// Assumes sample_tick is a single-cycle pulse.
module adc_init_timer #(
    parameter int INIT_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic tick,
    output logic ready
);
    localparam int CNT_W = $clog2(INIT_TICKS + 1);
    logic [CNT_W-1:0] cnt;

    // Count ticks since entering normal mode; clear on any exit.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (tick && !ready) begin
            if (cnt == CNT_W'(INIT_TICKS - 1)) begin
                ready <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_init_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !ready);
    p_init_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tick));
endmodule

// File: rtl/adc_scan_seq.sv
// Round-robin channel scanner and converter handshake.
// Assumes cnv_done arrives only for an outstanding conversion; others are dropped.
module adc_scan_seq #(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              tick,
    input  logic [NUM_CH-1:0] en_mask,
    input  logic              cnv_done,
    output logic              cnv_start,
    output logic [CH_W-1:0]   cnv_chan,
    output logic              busy,
    output logic              store_en
);
    logic [CH_W-1:0] last_q;
    logic [CH_W-1:0] pick;

    // Nearest enabled channel after the last completed one (wrapping).
    always_comb begin
        pick = last_q;
        for (int k = NUM_CH; k >= 1; k--) begin
            int cand;
            cand = (int'(last_q) + k) % NUM_CH;
            if (en_mask[cand]) pick = CH_W'(cand);
        end
    end

    // Start, hold and retire conversions; abandon on leaving running state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnv_start <= 1'b0;
            cnv_chan  <= '0;
            last_q    <= CH_W'(NUM_CH - 1);
        end else begin
            cnv_start <= 1'b0;
            if (!running) begin
                busy <= 1'b0;
            end else if (busy) begin
                if (cnv_done) begin
                    busy   <= 1'b0;
                    last_q <= cnv_chan;
                end
            end else if (tick && (|en_mask)) begin
                cnv_start <= 1'b1;
                cnv_chan  <= pick;
                busy      <= 1'b1;
            end
        end
    end

    // Result write strobe for the bank.
    assign store_en = running && busy && cnv_done;

    p_start_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> $past(running));
    p_single_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);
    p_start_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> (((($past(en_mask)) >> cnv_chan) & NUM_CH'(1)) != '0));
endmodule

// File: rtl/adc_result_bank.sv
// Per-channel result slots, zero-extended, held until rewritten.
// Assumes wr_idx is below NUM_CH.
module adc_result_bank #(
    parameter int NUM_CH = 16,
    parameter int RES_W  = 10,
    parameter int SLOT_W = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CH_W-1:0]               wr_idx,
    input  logic [RES_W-1:0]              wr_data,
    output logic [NUM_CH-1:0][SLOT_W-1:0] slots
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [SLOT_W-1:0] q;
        // Store a new conversion for this channel only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_idx == CH_W'(g))) begin
                q <= SLOT_W'(wr_data);
            end
        end
        assign slots[g] = q;
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
// Top: register port, read mux and converter-facing outputs of the scan controller.
// Assumes word-aligned accesses; reads are combinational from reg_addr.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int RES_W      = 10,
    parameter int INIT_TICKS = 4,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sample_tick,
    output logic              cnv_start,
    output logic [CH_W-1:0]   cnv_chan,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_result,
    output logic              cnv_comp,
    output logic              cnv_auto_comp,
    output logic [1:0]        cnv_ref,
    output logic              cnv_bat,
    output logic [TRIM_W-1:0] cnv_trim
);
    ctrl_t                          ctrl;
    logic                           running;
    logic                           ready;
    logic                           busy;
    logic                           store_en;
    logic [NUM_CH-1:0][SLOT_W-1:0]  res_slots;
    logic [5:0]                     idx;
    logic                           unused_addr;

    assign idx         = reg_addr[7:2];
    assign unused_addr = ^reg_addr[1:0];

    adc_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .idx     (idx),
        .wdata   (reg_wdata),
        .ctrl    (ctrl),
        .trim    (cnv_trim),
        .running (running)
    );

    adc_init_timer #(.INIT_TICKS(INIT_TICKS)) u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .tick    (sample_tick),
        .ready   (ready)
    );

    adc_scan_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .tick      (sample_tick),
        .en_mask   (ctrl.ch_en[NUM_CH-1:0]),
        .cnv_done  (cnv_done),
        .cnv_start (cnv_start),
        .cnv_chan  (cnv_chan),
        .busy      (busy),
        .store_en  (store_en)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .SLOT_W(SLOT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (cnv_chan),
        .wr_data (cnv_result),
        .slots   (res_slots)
    );

    // Mode bits passed to the converter; battery divider only on its channel.
    assign cnv_comp      = ctrl.comp;
    assign cnv_auto_comp = ctrl.auto_comp;
    assign cnv_ref       = ctrl.ref_sel;
    assign cnv_bat       = ctrl.ch7_bat && ctrl.bat_en && busy && (cnv_chan == CH_W'(BAT_CH));

    // Read mux: control word, packed result pairs, trim; zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        if (idx == CTRL_IDX) begin
            reg_rdata = {ctrl.ch_en, 2'b00, ctrl.bat_en, ctrl.ch7_bat, 3'b000, ready,
                         ctrl.ref_sel, ctrl.auto_comp, ctrl.comp, ctrl.mode, ctrl.eng_en};
        end else if (idx == TRIM_IDX) begin
            reg_rdata = {{(32-TRIM_W){1'b0}}, cnv_trim};
        end else begin
            for (int w = 0; w < NUM_CH / 2; w++) begin
                if (idx == 6'(RES_IDX0 + w)) reg_rdata = {res_slots[2*w+1], res_slots[2*w]};
            end
        end
    end

    p_store_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(store_en) |-> (res_slots[$past(cnv_chan)] == SLOT_W'($past(cnv_result))));
endmodule

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;
    localparam int NCH  = 16;
    localparam int RW   = 10;
    localparam int INIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sample_tick = 1'b0;
    logic        cnv_start;
    logic [3:0]  cnv_chan;
    logic        cnv_done = 1'b0;
    logic [RW-1:0] cnv_result = '0;
    logic        cnv_comp, cnv_auto_comp, cnv_bat;
    logic [1:0]  cnv_ref;
    logic [3:0]  cnv_trim;

    always #2 clk = ~clk;

    adc_scan_ctrl #(.NUM_CH(NCH), .RES_W(RW), .INIT_TICKS(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_tick(sample_tick),
        .cnv_start(cnv_start), .cnv_chan(cnv_chan), .cnv_done(cnv_done),
        .cnv_result(cnv_result), .cnv_comp(cnv_comp), .cnv_auto_comp(cnv_auto_comp),
        .cnv_ref(cnv_ref), .cnv_bat(cnv_bat), .cnv_trim(cnv_trim)
    );

    int compared = 0;
    int mismatched = 0;
    bit done_run = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_ctrl;
    logic [3:0]  m_trim;
    int          m_res[NCH];
    bit          m_busy, m_start, m_init, m_run;
    int          m_chan, m_last, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_trim = 0; m_busy = 0; m_start = 0; m_init = 0;
            m_chan = 0; m_last = NCH - 1; m_cnt = 0;
            foreach (m_res[i]) m_res[i] = 0;
        end else begin
            m_run = m_ctrl[0] && (m_ctrl[3:1] == 3'd7);
            m_start = 0;
            if (!m_run) begin
                m_cnt = 0; m_init = 0;
            end else if (sample_tick && !m_init) begin
                if (m_cnt == INIT - 1) begin m_init = 1; m_cnt = 0; end
                else m_cnt++;
            end
            if (!m_run) m_busy = 0;
            else if (m_busy) begin
                if (cnv_done) begin
                    m_res[m_chan] = int'(cnv_result);
                    m_busy = 0;
                    m_last = m_chan;
                end
            end else if (sample_tick && m_ctrl[31:16] != 0) begin
                bit found;
                found = 0;
                for (int k = 1; k <= NCH; k++) begin
                    int c;
                    c = (m_last + k) % NCH;
                    if (!found && m_ctrl[16 + c]) begin found = 1; m_chan = c; end
                end
                m_start = 1;
                m_busy = 1;
            end
            if (reg_wr) begin
                if (reg_addr[7:2] == 6'h00) m_ctrl = reg_wdata & 32'hFFFF_30FF;
                else if (reg_addr[7:2] == 6'h31) m_trim = reg_wdata[3:0];
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int w;
        w = int'(a[7:2]);
        if (w == 0) return m_ctrl | (m_init ? 32'h100 : 32'h0);
        if (w == 'h31) return {28'h0, m_trim};
        if (w >= 4 && w < 4 + NCH / 2)
            return {m_res[2*(w-4)+1][15:0], m_res[2*(w-4)][15:0]};
        return 32'h0;
    endfunction

    // ---------------- per-clock comparison ----------------
    bit active = 0;
    always @(negedge clk) begin
        if (active && rst_n) begin
            chk(cnv_start == m_start, "R3 start pulse", cnv_start, m_start);
            if (m_start) chk(int'(cnv_chan) == m_chan, "R4 scan channel", cnv_chan, m_chan);
            chk(cnv_bat == (m_busy && m_ctrl[12] && m_ctrl[13] && m_chan == 7), "R8 battery",
                cnv_bat, m_busy && m_ctrl[12] && m_ctrl[13] && m_chan == 7);
            chk(cnv_comp == m_ctrl[4], "R8 comp", cnv_comp, m_ctrl[4]);
            chk(cnv_auto_comp == m_ctrl[5], "R8 auto comp", cnv_auto_comp, m_ctrl[5]);
            chk(cnv_ref == m_ctrl[7:6], "R8 reference", cnv_ref, m_ctrl[7:6]);
            chk(cnv_trim == m_trim, "R9 trim out", cnv_trim, m_trim);
        end
    end

    // ---------------- environment: ticks, converter, start log ----------------
    bit tick_on = 0;
    int tick_per = 4;
    int tcnt = 0;
    initial forever begin
        @(negedge clk);
        tcnt++;
        sample_tick = tick_on && (tcnt % tick_per == 0);
    end

    bit conv_on = 1;
    int conv_lat = 3;
    int seed = 0;
    initial forever begin
        @(negedge clk);
        if (cnv_start && conv_on) begin
            int ch;
            ch = int'(cnv_chan);
            repeat (conv_lat) @(negedge clk);
            seed++;
            cnv_done = 1'b1;
            cnv_result = RW'(ch * 41 + seed * 7 + 1);
            @(negedge clk);
            cnv_done = 1'b0;
        end
    end

    int cyc = 0;
    int starts[$];
    int last_start = -1000;
    int min_gap = 1000000;
    always @(posedge clk) cyc++;
    always @(negedge clk) begin
        if (rst_n && cnv_start) begin
            starts.push_back(int'(cnv_chan));
            if (cyc - last_start < min_gap) min_gap = cyc - last_start;
            last_start = cyc;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_model(input logic [7:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == m_read(a), tag, reg_rdata, m_read(a));
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, tag, reg_rdata, e);
    endtask

    task automatic wait_start();
        while (starts.size() == 0) @(negedge clk);
    endtask

    task automatic stray_done(input logic [RW-1:0] v);
        @(negedge clk);
        cnv_done = 1'b1; cnv_result = v;
        @(negedge clk);
        cnv_done = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        compared++; mismatched++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    // ---------------- test sequence ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        active = 1;
        // R1: reset state
        rd_exp(8'h00, 32'h0, "R1 ctrl reset");
        rd_exp(8'h10, 32'h0, "R1 result reset");
        rd_exp(8'hC4, 32'h0, "R1 trim reset");
        chk(cnv_start == 1'b0, "R1 no start", cnv_start, 0);
        // R2: control field readback, read-only and reserved bits
        wr(8'h00, 32'hFFFF_FFFF);
        rd_exp(8'h00, 32'hFFFF_30FF, "R2 ctrl all ones");
        wr(8'h00, 32'h0000_0A55);
        rd_exp(8'h00, 32'h0000_0055, "R2 ctrl pattern");
        wr(8'h00, 32'h0);
        // R9: trim width and unmapped offsets
        wr(8'hC4, 32'hFFFF_FFFF);
        rd_exp(8'hC4, 32'h0000_000F, "R9 trim width");
        rd_exp(8'hC8, 32'h0, "R9 unmapped C8");
        rd_exp(8'hD0, 32'h0, "R9 unmapped D0");
        rd_exp(8'h40, 32'h0, "R9 unmapped 40");
        // R6: result offsets ignore writes
        wr(8'h10, 32'h1234_5678);
        rd_exp(8'h10, 32'h0, "R6 write ignored");
        // R3: standby and disabled normal start nothing
        tick_per = 3; tick_on = 1;
        wr(8'h00, 32'hFFFF_0003);
        repeat (30) @(negedge clk);
        chk(starts.size() == 0, "R3 standby idle", starts.size(), 0);
        wr(8'h00, 32'hFFFF_000E);
        repeat (30) @(negedge clk);
        chk(starts.size() == 0, "R3 disabled idle", starts.size(), 0);
        rd_exp(8'h00, 32'hFFFF_000E, "R7 no ready when off");
        // R4 and R7: scan order over channels 1, 4, 15
        tick_on = 0;
        wr(8'h00, 32'h8012_000F);
        rd_exp(8'h00, 32'h8012_000F, "R7 not ready yet");
        tick_per = 10; tick_on = 1;
        while (starts.size() < 4) @(negedge clk);
        chk(starts[0] == 1, "R4 first", starts[0], 1);
        chk(starts[1] == 4, "R4 second", starts[1], 4);
        chk(starts[2] == 15, "R4 third", starts[2], 15);
        chk(starts[3] == 1, "R4 wrap", starts[3], 1);
        rd_exp(8'h00, 32'h8012_010F, "R7 ready set");
        wr(8'h00, 32'h8012_0003);
        rd_exp(8'h00, 32'h8012_0003, "R7 ready cleared");
        // R5: ticks every cycle with long latency are dropped
        tick_on = 0;
        repeat (20) @(negedge clk);
        conv_lat = 20; tick_per = 1;
        starts.delete(); min_gap = 1000000; last_start = -1000;
        wr(8'h00, 32'h0001_000F);
        tick_on = 1;
        repeat (200) @(negedge clk);
        tick_on = 0;
        chk(starts.size() >= 3, "R5 several starts", starts.size(), 3);
        chk(min_gap > conv_lat, "R5 start spacing", min_gap, conv_lat + 1);
        // R8: battery sensing on channel 7
        repeat (40) @(negedge clk);
        conv_lat = 6; starts.delete();
        wr(8'h00, 32'h0080_30BF);
        tick_per = 50; tick_on = 1;
        wait_start();
        @(negedge clk);
        chk(cnv_bat == 1'b1, "R8 battery during ch7", cnv_bat, 1);
        chk(cnv_ref == 2'd2, "R8 reference value", cnv_ref, 2);
        chk(cnv_comp == 1'b1, "R8 comp value", cnv_comp, 1);
        repeat (10) @(negedge clk);
        chk(cnv_bat == 1'b0, "R8 battery after done", cnv_bat, 0);
        // R10: abandon then stray done
        tick_on = 0;
        repeat (60) @(negedge clk);
        conv_on = 0; starts.delete();
        wr(8'h00, 32'h0008_000F);
        tick_per = 4; tick_on = 1;
        wait_start();
        tick_on = 0;
        wr(8'h00, 32'h0008_0003);
        stray_done(10'h155);
        rd_exp(8'h14, 32'h0, "R10 abandoned result");
        conv_on = 1; conv_lat = 3; starts.delete();
        wr(8'h00, 32'h0008_000F);
        tick_on = 1;
        wait_start();
        tick_on = 0;
        repeat (8) @(negedge clk);
        rd_model(8'h14, "R10 later conversion");
        // R6: all channels, packed result words
        conv_lat = 2; tick_per = 5;
        wr(8'h00, 32'hFFFF_000F);
        tick_on = 1;
        repeat (300) @(negedge clk);
        tick_on = 0;
        repeat (10) @(negedge clk);
        for (int w = 0; w < NCH / 2; w++) rd_model(8'(8'h10 + 4 * w), "R6 result word");
        rd_exp(8'h10, {16'(10'(1 * 41 + 1) & 10'h0), 16'h0} | m_read(8'h10), "R6 packing");
        finish_run();
    end
endmodule